// File: doc/BRIEF.md
# Scan List Sequencer with Sample-Hold Control

This block runs multi-channel acquisition from a programmed list of channel entries. Software loads the list one 16-bit entry at a time while the sequencer is idle. A start pulse then launches acquisition. The sequencer works through the entries in order, and for each one it:

- presents the entry's on-board and extended channel/gain fields on its select outputs;
- waits a fixed settling interval;
- requests a conversion and holds the request until the converter answers;
- forwards the converted sample towards a data FIFO.

A flag bit in each entry marks where a scan begins, so one list can hold several scans back to back. The sample tick paces the start of every scan. Inside a scan, the entries follow one another at the settling spacing. Slow-settling gains can be given more time by listing the same entry several times in a row.

A second flag bit in each entry marks the entry after which the simultaneous sample-hold output drops into hold. The output returns to sample when the scan completes, and an end-of-scan pulse is raised at that point. In single mode one scan is run. In continuous mode scans repeat until a programmed number of scans has finished. If a result arrives while the FIFO is full, the result is discarded and a sticky overrun flag is set.

Top module: `scan_sequencer`

## Requirements
- R1: While idle, each `list_wr` stores `list_wdata` at the next list position. Writes after DEPTH entries are ignored. `list_clr` (which takes priority over `list_wr`) empties the list.
- R2: While `busy` is high, `list_wr` and `list_clr` have no effect on the list.
- R3: A `start` pulse while idle with a non-empty list raises `busy` on the next cycle and begins at entry 0. A `start` with an empty list is ignored. Every scan waits for a `sample_tick` before its first entry.
- R4: For each entry, `sel_main` = entry bits 14:8 and `sel_ext` = entry bits 7:0 are held stable. After SETTLE cycles of settling, `conv_req` rises and stays high until the cycle in which `conv_done` is high. The next entry of the same scan starts settling straight after.
- R5: A scan ends on the entry whose successor has bit 15 set, or on the last list entry. `eos` pulses for exactly one cycle, in the cycle after that entry's `conv_done`.
- R6: In single mode (`continuous`=0) acquisition stops after one scan. In continuous mode the next scan begins at the successor entry, wrapping from the last entry to entry 0. Acquisition stops once `scan_count` scans have completed, and a count of 0 acts as 1.
- R7: When a conversion completes and `fifo_full` is low, `fifo_push` pulses in the next cycle with `fifo_data` equal to `conv_data`.
- R8: When a conversion completes while `fifo_full` is high, the sample is dropped and `overrun` goes high. `overrun` stays high until the next accepted start.
- R9: `ssh` is high while idle. It goes low in the cycle after the `conv_done` of an entry with bit 6 set, and goes high again together with `eos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| list_wr | input | 1 | Append one entry to the list |
| list_wdata | input | 16 | Entry to append |
| list_clr | input | 1 | Empty the list |
| start | input | 1 | Begin acquisition |
| continuous | input | 1 | 1 = repeat scans, 0 = single scan |
| scan_count | input | CNT_W | Scans to run in continuous mode |
| sample_tick | input | 1 | Pacing tick for scan starts |
| conv_done | input | 1 | Converter finished |
| conv_data | input | DW | Converted sample |
| fifo_full | input | 1 | Data FIFO cannot accept |
| conv_req | output | 1 | Conversion request |
| sel_main | output | 7 | On-board channel and gain select |
| sel_ext | output | 8 | Extended channel and gain select |
| ssh | output | 1 | Sample (1) / hold (0) |
| eos | output | 1 | End-of-scan pulse |
| fifo_push | output | 1 | Write strobe to data FIFO |
| fifo_data | output | DW | Sample to data FIFO |
| busy | output | 1 | Acquisition in progress |
| overrun | output | 1 | Sticky dropped-sample flag |

## Verification
The bench builds the block with DEPTH=16, SETTLE=3 and CNT_W=4. With a list this short, filling it to capacity and writing past the end happen within a few dozen cycles. The short settling interval lets continuous runs of several scans, with the wrap from the last entry to entry 0, finish quickly. The small count width makes a scan count of zero an easy case to exercise.

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int DEPTH  = 512,
  parameter int SETTLE = 270,
  parameter int DW     = 12,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             list_wr,
  input  logic [15:0]      list_wdata,
  input  logic             list_clr,
  input  logic             start,
  input  logic             continuous,
  input  logic [CNT_W-1:0] scan_count,
  input  logic             sample_tick,
  input  logic             conv_done,
  input  logic [DW-1:0]    conv_data,
  input  logic             fifo_full,
  output logic             conv_req,
  output logic [6:0]       sel_main,
  output logic [7:0]       sel_ext,
  output logic             ssh,
  output logic             eos,
  output logic             fifo_push,
  output logic [DW-1:0]    fifo_data,
  output logic             busy,
  output logic             overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int SW = (SETTLE > 1) ? $clog2(SETTLE + 1) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SETL, S_CONV} st_t;

  st_t              st;
  logic [15:0]      mem [DEPTH];
  logic [LW-1:0]    wptr;
  logic [AW-1:0]    idx;
  logic [SW-1:0]    scnt;
  logic [CNT_W-1:0] done_scans;

  wire [LW-1:0]    idx_inc  = LW'(idx) + 1'b1;
  wire             wrap     = (idx_inc == wptr);
  wire [AW-1:0]    nxt      = wrap ? '0 : idx_inc[AW-1:0];
  wire [15:0]      cur      = mem[idx];
  wire             last     = wrap || mem[nxt][15];
  wire             fin      = conv_req && conv_done;
  wire [CNT_W-1:0] scans_nx = done_scans + 1'b1;
  wire             stop     = !continuous || (scans_nx >= scan_count);
  wire             go       = (st == S_IDLE) && start && (wptr != '0);

  assign busy     = (st != S_IDLE);
  assign conv_req = (st == S_CONV);
  assign sel_main = cur[14:8];
  assign sel_ext  = cur[7:0];

  always_ff @(posedge clk)
    if (!busy && list_wr && !list_clr && (wptr < LW'(DEPTH)))
      mem[wptr[AW-1:0]] <= list_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      wptr       <= '0;
      idx        <= '0;
      scnt       <= '0;
      done_scans <= '0;
      ssh        <= 1'b1;
      eos        <= 1'b0;
      fifo_push  <= 1'b0;
      fifo_data  <= '0;
      overrun    <= 1'b0;
    end else begin
      eos       <= 1'b0;
      fifo_push <= 1'b0;
      if (!busy) begin
        if (list_clr) wptr <= '0;
        else if (list_wr && (wptr < LW'(DEPTH))) wptr <= wptr + 1'b1;
      end
      case (st)
        S_IDLE: if (go) begin
          idx        <= '0;
          done_scans <= '0;
          overrun    <= 1'b0;
          st         <= S_WAIT;
        end
        S_WAIT: if (sample_tick) begin
          scnt <= '0;
          st   <= S_SETL;
        end
        S_SETL: if (scnt == SW'(SETTLE - 1)) st <= S_CONV;
                else scnt <= scnt + 1'b1;
        S_CONV: if (fin) begin
          if (fifo_full) overrun <= 1'b1;
          else begin
            fifo_push <= 1'b1;
            fifo_data <= conv_data;
          end
          if (cur[6]) ssh <= 1'b0;
          idx <= nxt;
          if (last) begin
            eos        <= 1'b1;
            ssh        <= 1'b1;
            done_scans <= scans_nx;
            st         <= stop ? S_IDLE : S_WAIT;
          end else begin
            scnt <= '0;
            st   <= S_SETL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req);
  a_r4_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> $stable(sel_main) && $stable(sel_ext));
  a_r5_eos_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eos |=> !eos);
  a_r7_push_source: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> $past(conv_req && conv_done && !fifo_full));
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !(start && !busy) |=> overrun);
  a_r9_ssh_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ssh);
endmodule

// File: tb/scan_sequencer_bench.sv
module scan_sequencer_bench;
  localparam int DEPTH = 16, SETTLE = 3, DW = 12, CNT_W = 4;

  logic clk = 0, rst_n = 0;
  logic list_wr = 0, list_clr = 0, start = 0, continuous = 0;
  logic [15:0] list_wdata = '0;
  logic [CNT_W-1:0] scan_count = '0;
  logic sample_tick = 0, conv_done = 0, fifo_full = 0;
  logic [DW-1:0] conv_data = '0;
  logic conv_req, ssh, eos, fifo_push, busy, overrun;
  logic [6:0] sel_main;
  logic [7:0] sel_ext;
  logic [DW-1:0] fifo_data;

  int checks = 0, errors = 0, push_cnt = 0, eos_cnt = 0;
  int tick_ctr = 0, adc_cnt = 0, adc_val = 5;

  always #5 clk = ~clk;

  scan_sequencer #(.DEPTH(DEPTH), .SETTLE(SETTLE), .DW(DW), .CNT_W(CNT_W)) u_scan_sequencer (
    .clk(clk), .rst_n(rst_n), .list_wr(list_wr), .list_wdata(list_wdata), .list_clr(list_clr),
    .start(start), .continuous(continuous), .scan_count(scan_count), .sample_tick(sample_tick),
    .conv_done(conv_done), .conv_data(conv_data), .fifo_full(fifo_full), .conv_req(conv_req),
    .sel_main(sel_main), .sel_ext(sel_ext), .ssh(ssh), .eos(eos), .fifo_push(fifo_push),
    .fifo_data(fifo_data), .busy(busy), .overrun(overrun));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 idle, 1 wait tick, 2 settle, 3 converting
  logic [15:0] lst[$];
  int m_st = 0, m_idx = 0, m_cnt = 0, m_scans = 0;
  bit m_ssh = 1, m_eos = 0, m_push = 0, m_ovr = 0;
  int m_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      lst.delete(); m_st = 0; m_idx = 0; m_ssh = 1; m_eos = 0; m_push = 0; m_ovr = 0; m_data = 0;
    end else begin
      bit was_idle;
      int sz;
      was_idle = (m_st == 0);
      sz = lst.size();
      m_eos = 0; m_push = 0;
      case (m_st)
        0: if (start && sz > 0) begin m_idx = 0; m_scans = 0; m_ovr = 0; m_st = 1; end
        1: if (sample_tick) begin m_cnt = 0; m_st = 2; end
        2: if (m_cnt == SETTLE - 1) m_st = 3; else m_cnt++;
        3: if (conv_done) begin
          int nx;
          bit lastp;
          if (fifo_full) m_ovr = 1; else begin m_push = 1; m_data = conv_data; end
          if (lst[m_idx][6]) m_ssh = 0;
          nx = (m_idx + 1 == sz) ? 0 : m_idx + 1;
          lastp = (m_idx + 1 == sz) || lst[nx][15];
          m_idx = nx;
          if (lastp) begin
            m_eos = 1; m_ssh = 1; m_scans++;
            m_st = (!continuous || m_scans >= scan_count) ? 0 : 1;
          end else begin m_cnt = 0; m_st = 2; end
        end
        default: m_st = 0;
      endcase
      if (was_idle) begin
        if (list_clr) lst.delete();
        else if (list_wr && sz < DEPTH) lst.push_back(list_wdata);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (m_st != 0), "R3", "busy", busy, m_st != 0);
      chk(conv_req == (m_st == 3), "R4", "conv_req", conv_req, m_st == 3);
      if (m_st >= 2) begin
        chk(sel_main == lst[m_idx][14:8], "R4", "sel_main", sel_main, lst[m_idx][14:8]);
        chk(sel_ext == lst[m_idx][7:0], "R4", "sel_ext", sel_ext, lst[m_idx][7:0]);
      end
      chk(eos == m_eos, "R5", "eos", eos, m_eos);
      chk(fifo_push == m_push, "R7", "fifo_push", fifo_push, m_push);
      if (m_push) chk(fifo_data == DW'(m_data), "R7", "fifo_data", fifo_data, m_data);
      chk(overrun == m_ovr, "R8", "overrun", overrun, m_ovr);
      chk(ssh == m_ssh, "R9", "ssh", ssh, m_ssh);
      if (fifo_push) push_cnt++;
      if (eos) eos_cnt++;
    end
    tick_ctr++;
    sample_tick = (tick_ctr % 13 == 0);
    conv_done = 0;
    if (conv_req) begin
      adc_cnt++;
      if (adc_cnt == 3) begin
        conv_done = 1; adc_val = (adc_val * 37 + 11) % 4096; conv_data = DW'(adc_val); adc_cnt = 0;
      end
    end else adc_cnt = 0;
  end

  task automatic put(input logic [15:0] v);
    @(negedge clk); list_wr = 1; list_wdata = v;
    @(negedge clk); list_wr = 0;
  endtask

  task automatic kick(input bit cont, input int cnt);
    @(negedge clk); continuous = cont; scan_count = CNT_W'(cnt); start = 1; push_cnt = 0; eos_cnt = 0;
    @(negedge clk); start = 0;
  endtask

  task automatic finish_run();
    int guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && ssh && !eos && !fifo_push && !overrun && !conv_req, "R9", "reset state",
        {busy, ssh, eos, fifo_push, overrun}, 5'b01000);

    // R1: four entries, repeated channel, sample-hold flag on entry 0
    put(16'h8540); put(16'h0312); put(16'h0312); put(16'h0701);
    kick(0, 0);
    chk(busy, "R3", "busy after start", busy, 1);
    finish_run();
    chk(push_cnt == 4, "R6", "single-mode pushes", push_cnt, 4);
    chk(eos_cnt == 1, "R5", "single-mode eos", eos_cnt, 1);

    // R2: writes and clear during a run are ignored; continuous 3 scans
    kick(1, 3);
    repeat (4) @(negedge clk);
    list_wr = 1; list_wdata = 16'h8F00; @(negedge clk); list_wr = 0;
    list_clr = 1; @(negedge clk); list_clr = 0;
    finish_run();
    chk(push_cnt == 12, "R2", "pushes with busy writes", push_cnt, 12);
    chk(eos_cnt == 3, "R6", "continuous eos", eos_cnt, 3);

    // R5: second start marker splits the list into two scans
    put(16'h8A00); put(16'h0B00);
    kick(1, 3);
    finish_run();
    chk(push_cnt == 10, "R5", "split-scan pushes", push_cnt, 10);
    chk(eos_cnt == 3, "R5", "split-scan eos", eos_cnt, 3);

    // R8: FIFO full drops every sample
    fifo_full = 1;
    kick(0, 0);
    finish_run();
    fifo_full = 0;
    chk(push_cnt == 0, "R8", "pushes while full", push_cnt, 0);
    chk(overrun, "R8", "overrun set", overrun, 1);
    kick(0, 0);
    chk(!overrun, "R8", "overrun cleared by start", overrun, 0);
    finish_run();
    chk(push_cnt == 4, "R6", "single scan up to second marker", push_cnt, 4);

    // R6: count zero acts as one scan
    kick(1, 0);
    finish_run();
    chk(eos_cnt == 1, "R6", "count zero eos", eos_cnt, 1);

    // R3: empty list start ignored
    @(negedge clk); list_clr = 1; @(negedge clk); list_clr = 0;
    kick(0, 0);
    repeat (3) @(negedge clk);
    chk(!busy, "R3", "start on empty list", busy, 0);

    // R1: fill past capacity
    put(16'h8040);
    for (int i = 1; i < DEPTH + 2; i++) put(16'h0100 | 16'(i));
    kick(0, 0);
    finish_run();
    chk(push_cnt == DEPTH, "R1", "full-list pushes", push_cnt, DEPTH);
    chk(eos_cnt == 1, "R1", "full-list eos", eos_cnt, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule